// File: doc/BRIEF.md
# Boot Vector Overlay Address Decoder

This block decodes a 24-bit byte address bus (16-bit data, word accesses) into chip selects for a small boot ROM and a low RAM that holds the exception vector table. The vector table fills the bottom 1024 bytes of the address space. Its first two longwords are the reset stack pointer and the reset program counter. Both must be valid the moment reset is released, so reads of the bottom eight bytes go to ROM. The decoder forces those reads into the ROM image by setting address bit 12, which turns byte 0x000000 into 0x001000.

Every other address in the low region goes to RAM. Software can rewrite that RAM at run time. Vectors the system never uses are loaded with the address of a spurious-exception handler. The ROM image can also be read directly through its own window. Writes aimed at ROM, whether through the overlay or through the window, never reach it. Depending on a parameter, the decoder either drops such a write silently or reports it on a bus-error output.

All outputs are registered. An access presented while the strobe is high at a rising clock edge produces its selects, error flag and remapped address during the following cycle.

Top module: `boot_overlay_decoder`

## Requirements
- R1: While rst_ni is low, rom_sel_o, ram_sel_o and bus_err_o are 0 and rom_addr_o is 0.
- R2: A clock edge that samples strobe_i low gives a following cycle with no select and no bus error, whatever the address.
- R3: A read (rd_i=1) of byte address 0x000000 to 0x000007 raises rom_sel_o only. rom_addr_o equals the address ORed with 0x001000, so the stack pointer comes from 0x001000 and the program counter from 0x001004.
- R4: A read or write of 0x000008 to 0x000FFF raises ram_sel_o only, including the first and last word of that range. rom_addr_o carries the unmodified address.
- R5: A read of the ROM window 0x001000 to 0x001FFF raises rom_sel_o with rom_addr_o unchanged.
- R6: A write (rd_i=0) to 0x000000 to 0x000007 or to the ROM window raises no select. With WR_FAULT=1 (the default), bus_err_o is 1 for that cycle. With WR_FAULT=0, the write is dropped silently.
- R7: Any access at 0x002000 or above raises no select and no bus error.
- R8: rom_sel_o and ram_sel_o are never 1 in the same cycle.
- R9: Outputs have a latency of exactly one cycle. They reflect the access sampled at the previous rising edge and drop in the cycle after the strobe goes low.
- R10: Vector entries read from RAM return the preloaded spurious-handler address. A run-time RAM write to a vector entry is returned by a later read of that entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| addr_i | input | 24 | Byte address of the current access |
| strobe_i | input | 1 | Address strobe, high while an access is valid |
| rd_i | input | 1 | 1 = read, 0 = write |
| rom_sel_o | output | 1 | Boot ROM chip select (registered) |
| ram_sel_o | output | 1 | Low RAM chip select (registered) |
| bus_err_o | output | 1 | Write-to-ROM fault (registered, WR_FAULT=1 only) |
| rom_addr_o | output | 24 | Address after the boot overlay, for the ROM (registered) |

## Verification
The bench probes both sides of every window edge: byte 7 against byte 8, 0x000FFE against 0x001000, and 0x001FFE against 0x002000. An off-by-one comparator would send a vector fetch to the wrong memory or return ROM data in place of RAM data. The stack-pointer and program-counter fetches are compared against the contents of the ROM image, so a missing bit-12 remap shows up as wrong boot words. Writes to the overlay and to the ROM window must raise the error flag with no select, so a decoder that let them through would raise a chip select. A run-time rewrite of a spurious-handler vector is read back, along with idle cycles that catch a select held over past the strobe.

// File: rtl/boot_ovl_pkg.sv
package boot_ovl_pkg;

  typedef enum logic [2:0] {
    ACC_NONE    = 3'd0,
    ACC_BOOT_RD = 3'd1,
    ACC_ROM_RD  = 3'd2,
    ACC_RAM     = 3'd3,
    ACC_FAULT   = 3'd4
  } acc_kind_e;

  typedef struct packed {
    logic rom_sel;
    logic ram_sel;
    logic bus_err;
  } sel_flags_t;

  function automatic sel_flags_t kind_to_flags(acc_kind_e kind, logic wr_fault);
    sel_flags_t f;
    f = '0;
    unique case (kind)
      ACC_BOOT_RD,
      ACC_ROM_RD: f.rom_sel = 1'b1;
      ACC_RAM:    f.ram_sel = 1'b1;
      ACC_FAULT:  f.bus_err = wr_fault;
      default:    f = '0;
    endcase
    return f;
  endfunction

endpackage

// File: rtl/bovl_window.sv
// Address window comparator; a zero base drops the lower-bound compare.
module bovl_window #(
  parameter int unsigned          ADDR_W = 24,
  parameter logic [ADDR_W-1:0]    BASE   = '0,
  parameter logic [ADDR_W-1:0]    SIZE   = 'h8
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);

  if (BASE == '0) begin : g_zero_base
    assign hit_o = addr_i < SIZE;
  end else begin : g_offset_base
    logic [ADDR_W-1:0] offset;
    assign offset = addr_i - BASE;
    assign hit_o  = (addr_i >= BASE) && (offset < SIZE);
  end

endmodule

// File: rtl/bovl_classify.sv
module bovl_classify
  import boot_ovl_pkg::*;
(
  input  logic      strobe_i,
  input  logic      rd_i,
  input  logic      boot_hit_i,
  input  logic      rom_hit_i,
  input  logic      ram_hit_i,
  output acc_kind_e kind_o
);

  // Priority: overlay beats RAM, ROM window beats RAM.
  always_comb begin
    kind_o = ACC_NONE;
    if (strobe_i) begin
      if (boot_hit_i)     kind_o = rd_i ? ACC_BOOT_RD : ACC_FAULT;
      else if (rom_hit_i) kind_o = rd_i ? ACC_ROM_RD  : ACC_FAULT;
      else if (ram_hit_i) kind_o = ACC_RAM;
    end
  end

endmodule

// File: rtl/bovl_remap.sv
module bovl_remap
  import boot_ovl_pkg::*;
#(
  parameter int unsigned       ADDR_W   = 24,
  parameter logic [ADDR_W-1:0] ROM_BASE = 'h1000
) (
  input  acc_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);

  assign addr_o = (kind_i == ACC_BOOT_RD) ? (addr_i | ROM_BASE) : addr_i;

endmodule

// File: rtl/bovl_out_reg.sv
module bovl_out_reg
  import boot_ovl_pkg::*;
#(
  parameter int unsigned ADDR_W   = 24,
  parameter bit          WR_FAULT = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  acc_kind_e         kind_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              rom_sel_o,
  output logic              ram_sel_o,
  output logic              bus_err_o,
  output logic [ADDR_W-1:0] addr_o
);

  sel_flags_t flags_d, flags_q;
  logic [ADDR_W-1:0] addr_q;

  assign flags_d = kind_to_flags(kind_i, WR_FAULT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
      addr_q  <= '0;
    end else begin
      flags_q <= flags_d;
      addr_q  <= addr_i;
    end
  end

  assign rom_sel_o = flags_q.rom_sel;
  assign ram_sel_o = flags_q.ram_sel;
  assign bus_err_o = flags_q.bus_err;
  assign addr_o    = addr_q;

endmodule

// File: rtl/boot_overlay_decoder.sv
module boot_overlay_decoder
  import boot_ovl_pkg::*;
#(
  parameter int unsigned       ADDR_W     = 24,
  parameter logic [ADDR_W-1:0] BOOT_BYTES = 'h8,
  parameter logic [ADDR_W-1:0] ROM_BASE   = 'h1000,
  parameter logic [ADDR_W-1:0] ROM_BYTES  = 'h1000,
  parameter logic [ADDR_W-1:0] RAM_BYTES  = 'h1000,
  parameter bit                WR_FAULT   = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              strobe_i,
  input  logic              rd_i,
  output logic              rom_sel_o,
  output logic              ram_sel_o,
  output logic              bus_err_o,
  output logic [ADDR_W-1:0] rom_addr_o
);

  logic              boot_hit, rom_hit, ram_hit;
  acc_kind_e         kind;
  logic [ADDR_W-1:0] remap_addr;

  bovl_window #(.ADDR_W(ADDR_W), .BASE('0), .SIZE(BOOT_BYTES)) u_boot_win (
    .addr_i(addr_i), .hit_o(boot_hit)
  );

  bovl_window #(.ADDR_W(ADDR_W), .BASE(ROM_BASE), .SIZE(ROM_BYTES)) u_rom_win (
    .addr_i(addr_i), .hit_o(rom_hit)
  );

  bovl_window #(.ADDR_W(ADDR_W), .BASE('0), .SIZE(RAM_BYTES)) u_ram_win (
    .addr_i(addr_i), .hit_o(ram_hit)
  );

  bovl_classify u_classify (
    .strobe_i  (strobe_i),
    .rd_i      (rd_i),
    .boot_hit_i(boot_hit),
    .rom_hit_i (rom_hit),
    .ram_hit_i (ram_hit),
    .kind_o    (kind)
  );

  bovl_remap #(.ADDR_W(ADDR_W), .ROM_BASE(ROM_BASE)) u_remap (
    .kind_i(kind), .addr_i(addr_i), .addr_o(remap_addr)
  );

  bovl_out_reg #(.ADDR_W(ADDR_W), .WR_FAULT(WR_FAULT)) u_out (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .kind_i   (kind),
    .addr_i   (remap_addr),
    .rom_sel_o(rom_sel_o),
    .ram_sel_o(ram_sel_o),
    .bus_err_o(bus_err_o),
    .addr_o   (rom_addr_o)
  );

endmodule

// File: rtl/boot_overlay_decoder_chk.sv
module boot_overlay_decoder_chk #(
  parameter int unsigned       ADDR_W     = 24,
  parameter logic [ADDR_W-1:0] BOOT_BYTES = 'h8,
  parameter logic [ADDR_W-1:0] ROM_BASE   = 'h1000,
  parameter logic [ADDR_W-1:0] ROM_BYTES  = 'h1000,
  parameter logic [ADDR_W-1:0] RAM_BYTES  = 'h1000,
  parameter bit                WR_FAULT   = 1'b1
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              strobe_i,
  input logic              rd_i,
  input logic              rom_sel_o,
  input logic              ram_sel_o,
  input logic              bus_err_o,
  input logic [ADDR_W-1:0] rom_addr_o
);

  logic [ADDR_W:0] rom_end;
  assign rom_end = {1'b0, ROM_BASE} + {1'b0, ROM_BYTES};

  // R8
  sel_mutex_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rom_sel_o && ram_sel_o));

  // R2
  idle_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !strobe_i |=> (!rom_sel_o && !ram_sel_o && !bus_err_o));

  // R3
  boot_redirect_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && rd_i && addr_i < BOOT_BYTES) |=>
      (rom_sel_o && !ram_sel_o && rom_addr_o == ($past(addr_i) | ROM_BASE)));

  // R4
  ram_route_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && addr_i >= BOOT_BYTES && addr_i < RAM_BYTES) |=>
      (ram_sel_o && !rom_sel_o && rom_addr_o == $past(addr_i)));

  // R6
  boot_wr_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && !rd_i && addr_i < BOOT_BYTES) |=>
      (!rom_sel_o && !ram_sel_o && bus_err_o == WR_FAULT));

  // R7
  unmapped_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (strobe_i && {1'b0, addr_i} >= rom_end) |=>
      (!rom_sel_o && !ram_sel_o && !bus_err_o));

endmodule

bind boot_overlay_decoder boot_overlay_decoder_chk #(
  .ADDR_W(ADDR_W), .BOOT_BYTES(BOOT_BYTES), .ROM_BASE(ROM_BASE),
  .ROM_BYTES(ROM_BYTES), .RAM_BYTES(RAM_BYTES), .WR_FAULT(WR_FAULT)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .strobe_i(strobe_i),
  .rd_i(rd_i), .rom_sel_o(rom_sel_o), .ram_sel_o(ram_sel_o),
  .bus_err_o(bus_err_o), .rom_addr_o(rom_addr_o)
);

// File: tb/boot_overlay_decoder_tb.sv
module boot_overlay_decoder_tb;

  localparam int CLK_PERIOD = 10;
  localparam int WORDS      = 2048;
  localparam logic [23:0] ROM_BASE = 24'h001000;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [23:0] addr = '0;
  logic        strobe = 1'b0;
  logic        rd = 1'b1;
  logic        rom_sel, ram_sel, bus_err;
  logic [23:0] rom_addr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [15:0] rom_mem [WORDS];
  logic [15:0] ram_mem [WORDS];

  typedef struct {
    logic [23:0] addr;
    logic        rd;
    logic [15:0] wdata;
    logic        e_rom, e_ram, e_err;
    logic [23:0] e_raddr;
    logic        chk_data;
    logic [15:0] e_data;
    string       req;
  } item_t;

  item_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  boot_overlay_decoder u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .strobe_i(strobe), .rd_i(rd),
    .rom_sel_o(rom_sel), .ram_sel_o(ram_sel), .bus_err_o(bus_err),
    .rom_addr_o(rom_addr)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // Driver: present one access for one cycle and queue what must follow.
  task automatic acc(input logic [23:0] a, input logic r, input logic [15:0] wd,
                     input logic e_rom, input logic e_ram, input logic e_err,
                     input logic [23:0] e_raddr, input logic cd,
                     input logic [15:0] ed, input string req);
    item_t it;
    @(negedge clk);
    addr = a; rd = r; strobe = 1'b1;
    it.addr = a; it.rd = r; it.wdata = wd; it.e_rom = e_rom; it.e_ram = e_ram;
    it.e_err = e_err; it.e_raddr = e_raddr; it.chk_data = cd; it.e_data = ed;
    it.req = req;
    q.push_back(it);
  endtask

  task automatic idle(input logic [23:0] a, input string req);
    item_t it;
    @(negedge clk);
    addr = a; rd = 1'b1; strobe = 1'b0;
    it.addr = a; it.rd = 1'b1; it.wdata = '0; it.e_rom = 0; it.e_ram = 0;
    it.e_err = 0; it.e_raddr = '0; it.chk_data = 0; it.e_data = '0;
    it.req = req;
    q.push_back(it);
  endtask

  // Monitor: outputs settle after the edge that samples the access.
  always begin
    item_t it;
    logic [15:0] rdata;
    @(posedge clk);
    #1;
    if (q.size() > 0) begin
      it = q.pop_front();
      check(rom_sel === it.e_rom, it.req, "rom_sel", 32'(rom_sel), 32'(it.e_rom));
      check(ram_sel === it.e_ram, it.req, "ram_sel", 32'(ram_sel), 32'(it.e_ram));
      check(bus_err === it.e_err, it.req, "bus_err", 32'(bus_err), 32'(it.e_err));
      // R8
      check(!(rom_sel && ram_sel), "R8", "both selects", {rom_sel, ram_sel}, 32'h0);
      if (it.e_rom || it.e_ram)
        check(rom_addr === it.e_raddr, it.req, "rom_addr", 32'(rom_addr), 32'(it.e_raddr));
      rdata = 16'hxxxx;
      if (ram_sel && !it.rd) ram_mem[it.addr[11:1]] = it.wdata;
      if (ram_sel && it.rd)  rdata = ram_mem[it.addr[11:1]];
      if (rom_sel)           rdata = rom_mem[11'((rom_addr - ROM_BASE) >> 1)];
      if (it.chk_data)
        check(rdata === it.e_data, it.req, "read data", 32'(rdata), 32'(it.e_data));
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=0 pending", q.size());
      summary();
    end
  end

  initial begin
    for (int i = 0; i < WORDS; i++) begin
      rom_mem[i] = 16'(i * 16'h0101) ^ 16'h5A5A;
      ram_mem[i] = i[0] ? 16'h1400 : 16'h0000;   // spurious handler at 0x001400
    end
    rom_mem[0] = 16'h00FF; rom_mem[1] = 16'hFE00;  // stack pointer 0x00FFFE00
    rom_mem[2] = 16'h0000; rom_mem[3] = 16'h1010;  // program counter 0x00001010

    // R1: reset state
    repeat (2) @(negedge clk);
    addr = 24'h000000; strobe = 1'b1;
    @(negedge clk);
    check(!rom_sel && !ram_sel && !bus_err && rom_addr == '0, "R1", "reset outputs",
          {rom_sel, ram_sel, bus_err, rom_addr}, 32'h0);
    strobe = 1'b0;
    rst_ni = 1'b1;

    // R2 / R9: idle after reset
    idle(24'h000100, "R2");

    // R3: boot fetches redirected to ROM image
    acc(24'h000000, 1, 0, 1, 0, 0, 24'h001000, 1, 16'h00FF, "R3");
    acc(24'h000002, 1, 0, 1, 0, 0, 24'h001002, 1, 16'hFE00, "R3");
    acc(24'h000004, 1, 0, 1, 0, 0, 24'h001004, 1, 16'h0000, "R3");
    acc(24'h000006, 1, 0, 1, 0, 0, 24'h001006, 1, 16'h1010, "R3");
    // R9: selects drop the cycle after the strobe falls
    idle(24'h000000, "R9");

    // R10: spurious handler vectors in RAM
    acc(24'h000100, 1, 0, 0, 1, 0, 24'h000100, 1, 16'h0000, "R10");
    acc(24'h000102, 1, 0, 0, 1, 0, 24'h000102, 1, 16'h1400, "R10");
    // R10: runtime rewrite, read back
    acc(24'h000102, 0, 16'h1234, 0, 1, 0, 24'h000102, 0, 0, "R10");
    acc(24'h000102, 1, 0, 0, 1, 0, 24'h000102, 1, 16'h1234, "R10");

    // R4: RAM window edges
    acc(24'h000008, 1, 0, 0, 1, 0, 24'h000008, 1, 16'h0000, "R4");
    acc(24'h000FFE, 1, 0, 0, 1, 0, 24'h000FFE, 1, 16'h1400, "R4");
    acc(24'h000008, 0, 16'hBEEF, 0, 1, 0, 24'h000008, 0, 0, "R4");
    acc(24'h000008, 1, 0, 0, 1, 0, 24'h000008, 1, 16'hBEEF, "R4");

    // R6: writes toward ROM blocked and flagged
    acc(24'h000000, 0, 16'hDEAD, 0, 0, 1, 24'h0, 0, 0, "R6");
    acc(24'h000006, 0, 16'hDEAD, 0, 0, 1, 24'h0, 0, 0, "R6");
    acc(24'h001000, 0, 16'hDEAD, 0, 0, 1, 24'h0, 0, 0, "R6");
    acc(24'h000000, 1, 0, 1, 0, 0, 24'h001000, 1, 16'h00FF, "R6");

    // R5: direct ROM window reads
    acc(24'h001010, 1, 0, 1, 0, 0, 24'h001010, 1, 16'(8 * 16'h0101) ^ 16'h5A5A, "R5");
    acc(24'h001FFE, 1, 0, 1, 0, 0, 24'h001FFE, 1, 16'(2047 * 16'h0101) ^ 16'h5A5A, "R5");

    // R7: beyond mapped space
    acc(24'h002000, 1, 0, 0, 0, 0, 24'h0, 0, 0, "R7");
    acc(24'h7FF000, 0, 16'h1111, 0, 0, 0, 24'h0, 0, 0, "R7");
    acc(24'hFFFFFE, 1, 0, 0, 0, 0, 24'h0, 0, 0, "R7");

    // R2: strobe low on a boot address
    idle(24'h000004, "R2");
    idle(24'h000104, "R2");

    @(negedge clk);
    strobe = 1'b0;
    repeat (3) @(negedge clk);
    check(q.size() == 0, "R9", "pending items", 32'(q.size()), 32'h0);
    done = 1'b1;
    summary();
  end

endmodule